// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Interpreter

This block sits on the device side of a byte-wide flash part and is modelled with a synchronous clock. Each bus write arrives as a single-cycle strobe that carries a 17-bit address and an 8-bit value. The block checks these writes against a fixed grammar: two key writes, then a command write, and for erase a second key pair and a final command. A complete sequence sends one request to a memory and timer backend. The request is a single-cycle start pulse with a kind code, an address and a data byte. The backend answers with a done pulse when the embedded operation has finished.

While the request is outstanding, the interpreter ignores every write, including a reset command. A write that breaks the grammar at any point puts the block back into plain array-read mode.

A third command enters an identification mode. In that mode a read returns one of three things, chosen by the low address byte: a manufacturer code, a device code, or the protection state of the addressed sector. The protection state comes from an 8-bit per-sector protect input.

A program aimed at a protected sector sends no request to the backend. Instead the block holds itself busy for a fixed number of cycles, ignores writes for that time, and then returns to array read. The block does not model the storage array, the pulse timing, or the window in which further sector-erase commands are collected.

Top module: `fcmd_top`

## Requirements
- R1: After reset the block is in array-read mode, `op_start` is 0, `op_kind` is 0 and `rdata` is 00h. A read at low byte 01h returns 00h.
- R2: Key writes are matched on the address bits [14:0] only. The first key is AAh at 5555h. The second key is 55h at 2AAAh. The command write goes to 5555h and is A0h for program, 80h for erase or 90h for identification. Address bits [16:15] are ignored.
- R3: After the program command, the next write starts an operation, unless its sector is protected. `op_start` is high for one cycle, `op_kind` is 01b, and `op_addr` and `op_data` carry that write's address and data.
- R4: After the erase command, a write sequence of AAh at 5555h, then 55h at 2AAAh, then 10h at 5555h starts a whole-array erase. `op_kind` is 10b and `op_addr` is the address of the last write.
- R5: In the same position as the final write of R4, a write of 30h at any address starts a sector erase. `op_kind` is 11b and `op_addr` is that address; its bits [16:14] name the sector.
- R6: In identification mode, the cycle after a read strobe, `rdata` depends on the address of the read:

  | Address bits [7:0] | `rdata` |
  |---|---|
  | 00h | 01h |
  | 01h | 20h |
  | 02h | 01h if the sector named by address bits [16:14] is protected (its bit in `prot` is 1), else 00h |
  | any other value | 00h |

  Outside identification mode, `rdata` is 00h the cycle after a read strobe.
- R7: Any write in identification mode returns the block to array read. This includes F0h.
- R8: A write that does not match the next expected step of a sequence returns the block to array read and starts nothing. This includes F0h at any address. The one exception is the data write after a program command, which is accepted with any value.
- R9: From a start pulse until `op_done`, every write is ignored and `op_kind`, `op_addr` and `op_data` stay stable. `op_done` returns the block to array read.
- R10: A program write whose sector has its `prot` bit set produces no start pulse. The block then ignores writes for `PROT_HOLD` cycles and returns to array read.
- R11: `op_start` never lasts more than one cycle. An `op_done` pulse that arrives while no operation is outstanding changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | Single-cycle bus write strobe |
| rd_stb | input | 1 | Single-cycle bus read strobe |
| addr | input | 17 | Bus address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Identification read data, updated the cycle after `rd_stb` |
| prot | input | 8 | Per-sector protect flags, bit n for sector n |
| op_start | output | 1 | One-cycle request pulse to the backend |
| op_kind | output | 2 | Request kind: 01 program, 10 whole-array erase, 11 sector erase |
| op_addr | output | 17 | Request address |
| op_data | output | 8 | Program data (00h for erase requests) |
| op_done | input | 1 | Backend completion pulse |

## Verification
The bench breaks sequences at every position, including the last erase step. A design that starts an operation on a partial match, or that stays in a half-unlocked state, would emit a spurious `op_start` there, or would leave a later lone command live.

The bench also issues full unlock-plus-identification sequences while an operation is outstanding and while a protected program is held. A design that leaks writes in those periods would return 20h on the next read instead of 00h.

Identification reads cover every sector with an irregular protect pattern, and they also read unlisted offsets. A swapped sector index or a loose offset decode shows up as a wrong byte.

Stray `op_done` pulses and key writes with the upper address bits set check that neither of them changes the mode.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    // Interpreter states
    typedef enum logic [3:0] {
        ST_ARRAY,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_ARM,
        ST_ERS_ARM,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_IDENT,
        ST_BUSY,
        ST_PHOLD
    } fsm_e;

    // Backend request kinds
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_CHIP = 2'b10,
        OP_SECT = 2'b11
    } op_kind_e;

    // Classification of a single bus write
    typedef enum logic [2:0] {
        WC_OTHER,
        WC_KEY1,
        WC_KEY2,
        WC_PROG,
        WC_ERASE,
        WC_IDENT,
        WC_CHIP,
        WC_SECT
    } wcls_e;

    localparam logic [7:0] KEY1_DATA  = 8'hAA;
    localparam logic [7:0] KEY2_DATA  = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_CHIP   = 8'h10;
    localparam logic [7:0] CMD_SECT   = 8'h30;
    localparam logic [14:0] KEY1_ADDR = 15'h5555;
    localparam logic [14:0] KEY2_ADDR = 15'h2AAA;

endpackage

// File: rtl/fcmd_match.sv
module fcmd_match
    import fcmd_pkg::*;
#(
    parameter int CAW = 15
) (
    input  logic [CAW-1:0] caddr,
    input  logic [7:0]     wdata,
    output wcls_e          cls
);

    localparam logic [CAW-1:0] A_KEY1 = CAW'(KEY1_ADDR);
    localparam logic [CAW-1:0] A_KEY2 = CAW'(KEY2_ADDR);

    logic at_key1;
    logic at_key2;

    assign at_key1 = (caddr == A_KEY1);
    assign at_key2 = (caddr == A_KEY2);

    always_comb begin
        cls = WC_OTHER;
        if (at_key1) begin
            unique case (wdata)
                KEY1_DATA: cls = WC_KEY1;
                CMD_PROG:  cls = WC_PROG;
                CMD_ERASE: cls = WC_ERASE;
                CMD_IDENT: cls = WC_IDENT;
                CMD_CHIP:  cls = WC_CHIP;
                CMD_SECT:  cls = WC_SECT;
                default:   cls = WC_OTHER;
            endcase
        end else if (at_key2 && wdata == KEY2_DATA) begin
            cls = WC_KEY2;
        end else if (wdata == CMD_SECT) begin
            cls = WC_SECT;
        end
    end

endmodule

// File: rtl/fcmd_ident.sv
module fcmd_ident #(
    parameter int          SECT_N = 8,
    parameter int          DW     = 8,
    parameter logic [7:0]  MFR_ID = 8'h01,
    parameter logic [7:0]  DEV_ID = 8'h20,
    localparam int         SB     = $clog2(SECT_N)
) (
    input  logic [7:0]        offs,
    input  logic [SB-1:0]     sec,
    input  logic [SECT_N-1:0] prot,
    output logic [DW-1:0]     code
);

    always_comb begin
        unique case (offs)
            8'h00:   code = DW'(MFR_ID);
            8'h01:   code = DW'(DEV_ID);
            8'h02:   code = DW'(prot[sec]);
            default: code = '0;
        endcase
    end

endmodule

// File: rtl/fcmd_hold.sv
module fcmd_hold #(
    parameter int  HOLD = 400,
    localparam int CW   = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic done
);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.act = 1'b1;
            d.cnt = CW'(HOLD - 1);
        end else if (q.act) begin
            if (q.cnt == '0) begin
                d.act = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign active = q.act;
    assign done   = q.act && (q.cnt == '0);

    p_hold_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.act |-> (q.cnt < CW'(HOLD)));

    p_hold_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !active);

endmodule

// File: rtl/fcmd_top.sv
module fcmd_top
    import fcmd_pkg::*;
#(
    parameter int         AW        = 17,
    parameter int         DW        = 8,
    parameter int         SECT_N    = 8,
    parameter int         CAW       = 15,
    parameter int         PROT_HOLD = 400,
    parameter logic [7:0] MFR_ID    = 8'h01,
    parameter logic [7:0] DEV_ID    = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [SECT_N-1:0] prot,
    output logic              op_start,
    output logic [1:0]        op_kind,
    output logic [AW-1:0]     op_addr,
    output logic [DW-1:0]     op_data,
    input  logic              op_done
);

    localparam int SB = $clog2(SECT_N);

    typedef struct packed {
        fsm_e          st;
        logic          start;
        op_kind_e      kind;
        logic [AW-1:0] oaddr;
        logic [DW-1:0] odata;
        logic [DW-1:0] rdat;
    } regs_t;

    regs_t q, d;

    wcls_e         cls;
    logic [DW-1:0] id_code;
    logic [SB-1:0] sec;
    logic          hold_go;
    logic          hold_act;
    logic          hold_done;

    assign sec = addr[AW-1 -: SB];

    fcmd_match #(.CAW(CAW)) i_match (
        .caddr (addr[CAW-1:0]),
        .wdata (wdata[7:0]),
        .cls   (cls)
    );

    fcmd_ident #(
        .SECT_N (SECT_N),
        .DW     (DW),
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) i_ident (
        .offs (addr[7:0]),
        .sec  (sec),
        .prot (prot),
        .code (id_code)
    );

    fcmd_hold #(.HOLD(PROT_HOLD)) i_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (hold_go),
        .active (hold_act),
        .done   (hold_done)
    );

    always_comb begin
        d       = q;
        d.start = 1'b0;
        hold_go = 1'b0;

        if (rd_stb) begin
            d.rdat = (q.st == ST_IDENT) ? id_code : '0;
        end

        if (wr_stb) begin
            unique case (q.st)
                ST_ARRAY:    d.st = (cls == WC_KEY1) ? ST_UNL1 : ST_ARRAY;
                ST_UNL1:     d.st = (cls == WC_KEY2) ? ST_UNL2 : ST_ARRAY;
                ST_UNL2: begin
                    unique case (cls)
                        WC_PROG:  d.st = ST_PGM_ARM;
                        WC_ERASE: d.st = ST_ERS_ARM;
                        WC_IDENT: d.st = ST_IDENT;
                        default:  d.st = ST_ARRAY;
                    endcase
                end
                ST_PGM_ARM: begin
                    if (prot[sec]) begin
                        d.st    = ST_PHOLD;
                        hold_go = 1'b1;
                    end else begin
                        d.st    = ST_BUSY;
                        d.start = 1'b1;
                        d.kind  = OP_PROG;
                        d.oaddr = addr;
                        d.odata = wdata;
                    end
                end
                ST_ERS_ARM:  d.st = (cls == WC_KEY1) ? ST_ERS_UNL1 : ST_ARRAY;
                ST_ERS_UNL1: d.st = (cls == WC_KEY2) ? ST_ERS_UNL2 : ST_ARRAY;
                ST_ERS_UNL2: begin
                    if (cls == WC_CHIP || cls == WC_SECT) begin
                        d.st    = ST_BUSY;
                        d.start = 1'b1;
                        d.kind  = (cls == WC_CHIP) ? OP_CHIP : OP_SECT;
                        d.oaddr = addr;
                        d.odata = '0;
                    end else begin
                        d.st = ST_ARRAY;
                    end
                end
                ST_IDENT:    d.st = ST_ARRAY;
                default:     d.st = q.st;
            endcase
        end

        if (q.st == ST_BUSY && op_done) begin
            d.st = ST_ARRAY;
        end
        if (q.st == ST_PHOLD && hold_done) begin
            d.st = ST_ARRAY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_ARRAY;
            q.start <= 1'b0;
            q.kind  <= OP_NONE;
            q.oaddr <= '0;
            q.odata <= '0;
            q.rdat  <= '0;
        end else begin
            q <= d;
        end
    end

    assign op_start = q.start;
    assign op_kind  = q.kind;
    assign op_addr  = q.oaddr;
    assign op_data  = q.odata;
    assign rdata    = q.rdat;

    p_start_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BUSY && !op_done) |=>
            (q.st == ST_BUSY && !op_start && $stable(op_addr)
             && $stable(op_kind) && $stable(op_data)));

    p_prot_nostart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PGM_ARM && wr_stb && prot[sec]) |=> (!op_start && hold_act));

    p_hold_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PHOLD && !hold_done) |=> (q.st == ST_PHOLD));

    p_ident_dev_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && q.st == ST_IDENT && addr[7:0] == 8'h01) |=> (rdata == DW'(DEV_ID)));

    p_nonident_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && q.st != ST_IDENT) |=> (rdata == '0));

    p_ident_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && q.st == ST_IDENT) |=> (q.st == ST_ARRAY));

    p_idle_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !wr_stb && q.st == ST_IDENT) |=> (q.st == ST_IDENT));

endmodule

// File: tb/test_fcmd_top.sv
`timescale 1ns/1ps
module test_fcmd_top;

    localparam int HOLD = 20;
    localparam int M_ARR = 0, M_U1 = 1, M_U2 = 2, M_PA = 3, M_EA = 4,
                   M_E1 = 5, M_E2 = 6, M_ID = 7, M_BUSY = 8, M_HOLD = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  prot = '0;
    logic        op_start;
    logic [1:0]  op_kind;
    logic [16:0] op_addr;
    logic [7:0]  op_data;
    logic        op_done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int mode = M_ARR;

    always #2.5 clk = ~clk;

    fcmd_top #(.PROT_HOLD(HOLD)) i_fcmd_top (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .addr(addr), .wdata(wdata), .rdata(rdata), .prot(prot),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
        .op_data(op_data), .op_done(op_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_next(input int m, input logic [16:0] a,
                                    input logic [7:0] dd, input logic [7:0] pr,
                                    output bit st, output logic [1:0] k);
        bit at5 = (a[14:0] == 15'h5555);
        bit at2 = (a[14:0] == 15'h2AAA);
        st = 1'b0;
        k  = 2'b00;
        case (m)
            M_ARR: return (at5 && dd == 8'hAA) ? M_U1 : M_ARR;
            M_U1:  return (at2 && dd == 8'h55) ? M_U2 : M_ARR;
            M_U2: begin
                if (at5 && dd == 8'hA0) return M_PA;
                if (at5 && dd == 8'h80) return M_EA;
                if (at5 && dd == 8'h90) return M_ID;
                return M_ARR;
            end
            M_PA: begin
                if (pr[a[16:14]]) return M_HOLD;
                st = 1'b1; k = 2'b01;
                return M_BUSY;
            end
            M_EA:  return (at5 && dd == 8'hAA) ? M_E1 : M_ARR;
            M_E1:  return (at2 && dd == 8'h55) ? M_E2 : M_ARR;
            M_E2: begin
                if (at5 && dd == 8'h10) begin st = 1'b1; k = 2'b10; return M_BUSY; end
                if (dd == 8'h30) begin st = 1'b1; k = 2'b11; return M_BUSY; end
                return M_ARR;
            end
            M_ID:  return M_ARR;
            default: return m;
        endcase
    endfunction

    function automatic logic [7:0] exp_id(input logic [16:0] a, input logic [7:0] pr);
        case (a[7:0])
            8'h00: return 8'h01;
            8'h01: return 8'h20;
            8'h02: return {7'b0, pr[a[16:14]]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic do_wr(input logic [16:0] a, input logic [7:0] dd, input string req);
        bit st;
        logic [1:0] k;
        int nm;
        nm = exp_next(mode, a, dd, prot, st, k);
        @(negedge clk);
        wr_stb = 1'b1; addr = a; wdata = dd;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(op_start == st, req, "op_start after write", op_start, st);
        if (st) begin
            chk(op_kind == k, req, "op_kind", op_kind, k);
            chk(op_addr == a, req, "op_addr", op_addr, a);
            chk(op_data == ((k == 2'b01) ? dd : 8'h00), req, "op_data", op_data,
                (k == 2'b01) ? dd : 8'h00);
        end
        mode = nm;
    endtask

    task automatic do_rd(input logic [16:0] a, input string req);
        logic [7:0] e;
        e = (mode == M_ID) ? exp_id(a, prot) : 8'h00;
        @(negedge clk);
        rd_stb = 1'b1; addr = a;
        @(negedge clk);
        rd_stb = 1'b0;
        chk(rdata == e, req, "rdata", rdata, e);
    endtask

    task automatic finish_op();
        if (mode == M_BUSY) begin
            repeat ($urandom % 4) @(negedge clk);
            @(negedge clk); op_done = 1'b1;
            @(negedge clk); op_done = 1'b0;
            mode = M_ARR;
        end else if (mode == M_HOLD) begin
            repeat (HOLD + 3) @(negedge clk);
            mode = M_ARR;
        end
    endtask

    task automatic unlock(input logic [1:0] hi, input string req);
        do_wr({hi, 15'h5555}, 8'hAA, req);
        do_wr({hi, 15'h2AAA}, 8'h55, req);
    endtask

    task automatic enter_ident(input string req);
        unlock(2'b00, req);
        do_wr(17'h05555, 8'h90, req);
    endtask

    task automatic erase_pre(input string req);
        unlock(2'b00, req);
        do_wr(17'h05555, 8'h80, req);
        unlock(2'b00, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(op_start == 1'b0, "R1", "op_start at reset", op_start, 0);
        chk(op_kind == 2'b00, "R1", "op_kind at reset", op_kind, 0);
        chk(rdata == 8'h00, "R1", "rdata at reset", rdata, 0);
        do_rd(17'h00001, "R1");

        // R2, R3: program, then writes during busy are ignored (R9)
        unlock(2'b11, "R2");
        do_wr(17'h05555, 8'hA0, "R2");
        do_wr(17'h0ABCD, 8'h3C, "R3");
        enter_ident("R9");
        do_rd(17'h00001, "R9");
        chk(op_addr == 17'h0ABCD && op_kind == 2'b01, "R9", "fields stable in busy",
            {op_kind, op_addr}, {2'b01, 17'h0ABCD});
        finish_op();

        // R6: identification reads
        prot = 8'hA5;
        enter_ident("R6");
        do_rd(17'h1F300, "R6");
        do_rd(17'h00001, "R6");
        for (int s = 0; s < 8; s++) do_rd({s[2:0], 14'h0002}, "R6");
        do_rd(17'h00003, "R6");
        // R11: stray op_done leaves identification mode intact
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        do_rd(17'h00001, "R11");
        // R7: F0 exits, and so does any other write
        do_wr(17'h12345, 8'hF0, "R7");
        do_rd(17'h00001, "R7");
        enter_ident("R7");
        do_wr(17'h05555, 8'hAA, "R7");
        do_rd(17'h00001, "R7");
        mode = M_ARR;

        // R4, R5: erases
        prot = 8'h00;
        erase_pre("R4");
        do_wr(17'h15555, 8'h10, "R4");
        finish_op();
        erase_pre("R5");
        do_wr(17'h1C123, 8'h30, "R5");
        finish_op();
        erase_pre("R5");
        do_wr(17'h05555, 8'h30, "R5");
        finish_op();

        // R8: broken sequences
        unlock(2'b00, "R8");
        do_wr(17'h05555, 8'hF0, "R8");
        do_wr(17'h05555, 8'hA0, "R8");
        do_wr(17'h01234, 8'h77, "R8");
        erase_pre("R8");
        do_wr(17'h00000, 8'hF0, "R8");
        do_wr(17'h05555, 8'h10, "R8");
        erase_pre("R8");
        do_wr(17'h04444, 8'h10, "R8");
        do_wr(17'h05555, 8'h30, "R8");
        do_wr(17'h05555, 8'hAA, "R8");
        do_wr(17'h05555, 8'h55, "R8");
        do_wr(17'h05555, 8'h90, "R8");
        do_rd(17'h00001, "R8");

        // R10: protected program
        prot = 8'h20;
        unlock(2'b00, "R10");
        do_wr(17'h05555, 8'hA0, "R10");
        do_wr(17'h14007, 8'h00, "R10");
        enter_ident("R10");
        do_rd(17'h00001, "R10");
        finish_op();
        enter_ident("R10");
        do_rd(17'h00001, "R10");
        do_wr(17'h00000, 8'hF0, "R10");

        // Constrained random mix
        prot = 8'($urandom);
        for (int it = 0; it < 400; it++) begin
            int pick;
            logic [16:0] ra;
            ra = 17'($urandom);
            pick = $urandom % 12;
            case (pick)
                0: begin unlock(2'($urandom), "R2"); do_wr(17'h05555, 8'hA0, "R3");
                          do_wr(ra, 8'($urandom), "R3"); end
                1: begin erase_pre("R4"); do_wr({2'($urandom), 15'h5555}, 8'h10, "R4"); end
                2: begin erase_pre("R5"); do_wr(ra, 8'h30, "R5"); end
                3: begin enter_ident("R6"); do_rd({ra[16:8], 6'h0, 2'($urandom % 3)}, "R6"); end
                4: do_wr({2'($urandom), 15'h5555}, 8'hAA, "R8");
                5: do_wr({2'($urandom), 15'h2AAA}, 8'h55, "R8");
                6: do_wr(17'h05555, ($urandom % 2) ? 8'hA0 : 8'h80, "R8");
                7: do_wr(17'h05555, ($urandom % 2) ? 8'h90 : 8'h10, "R8");
                8: do_wr(ra, 8'hF0, "R8");
                9: do_wr(ra, 8'($urandom), "R8");
                10: do_rd({ra[16:8], 6'h0, 2'($urandom)}, "R6");
                default: do_wr(ra, 8'h30, "R8");
            endcase
            finish_op();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule